// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is a serial test access port for a small device. It is clocked by the test clock, steered by the mode-select line and moved by the serial data input and output. A sixteen-state controller walks the standard capture, shift and update sequences. A four-bit instruction register chooses which data register sits between serial input and serial output. There are three data registers. The first is a boundary chain of four cells per bidirectional port pin. The second is a single reset bit. The third is a one-bit bypass stage.

Each port pin has a pull-up disable, an output enable and an output value. The core normally drives these. While the external-test instruction is active, update latches in the boundary chain take over all three. The reset instruction gives a way to tri-state the pins without a dedicated high-impedance instruction. Shifting a 1 into its one-bit register raises a device reset request at once. While that request is high, every output enable is forced off.

Top module: `tap_bscan_ctrl`

## Requirements
- R1: After a low `rst_n` at a rising test clock edge, and whenever the controller passes through Test-Logic-Reset, the instruction becomes BYPASS (4'hF) and the reset bit clears, so `core_rst_req` is 0. The pins then follow the core signals, and `tdo_en` is 0.
- R2: In Capture-IR the instruction shift register loads 4'b0001. Shift-IR presents this value on `tdo` least-significant bit first, so the first bit out is 1.
- R3: Opcode 4'hF selects the bypass bit, and so does every opcode other than 4'h0 and 4'hC. The bypass bit captures 0 and delays `tdi` by one shift, so the shifted-out word equals the shifted-in word moved up one place with a 0 at bit 0.
- R4: Opcode 4'h0 (EXTEST) selects the boundary chain of 4*NPINS cells. Pin i owns cell 4i (pull-up disable), 4i+1 (output enable), 4i+2 (output value) and 4i+3 (input level). Cell 0 leaves on `tdo` first, and `tdi` enters at the top cell.
- R5: In Capture-DR under EXTEST, cells 4i to 4i+2 load `core_pud[i]`, `core_oe[i]` and `core_out[i]`, and cell 4i+3 loads `pin_in[i]`.
- R6: While EXTEST is the active instruction, `pin_pud`, `pin_oe` and `pin_out` come from the update latches. This starts right after Update-IR loads EXTEST. The latches change only in Update-DR, so they do not change during Shift-DR or Exit1-DR.
- R7: Opcode 4'hC selects the one-bit reset register. `core_rst_req` equals that bit and changes at the Shift-DR clock edge that shifts it, with no Update-DR needed. It stays 1 until a 0 is shifted in or Test-Logic-Reset is reached.
- R8: While `core_rst_req` is 1 and EXTEST is not active, every bit of `pin_oe` is 0.
- R9: `tdo` and `tdo_en` change only on the falling test clock edge. `tdo_en` is 1 only during Shift-IR and Shift-DR, and it rises at the falling edge after the controller enters a shift state.
- R10: Five rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and it stays there while `tms` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | Drive enable for tdo, high in shift states |
| core_pud | input | NPINS | Pull-up disable from the functional core |
| core_oe | input | NPINS | Output enable from the functional core |
| core_out | input | NPINS | Output value from the functional core |
| core_in | output | NPINS | Pin input levels passed to the core |
| pin_pud | output | NPINS | Pull-up disable to the pads |
| pin_oe | output | NPINS | Output enable to the pads |
| pin_out | output | NPINS | Output value to the pads |
| pin_in | input | NPINS | Input levels from the pads |
| core_rst_req | output | 1 | Device reset request from the reset register |

## Verification
The instruction path is driven with the fixed capture pattern, with BYPASS, with an unused opcode, with EXTEST and with the reset opcode. Comparing the shifted-out words shows whether the decode selects the right register and whether the bits leave in the right order. The boundary chain is captured from core and pad values that differ from cell to cell, then loaded with an irregular word. A cell moved to the wrong position, or a wrong choice between core and pad sources, gives a different readout or pad state. Pads are observed right after EXTEST loads and again before and after Update-DR; these three points tell an immediate handover apart from a late handover or from latches that follow the shift. The reset bit is read in Exit1-DR before any update, then after a walk to Test-Logic-Reset with five TMS-high clocks. This shows that the bit is unlatched, that it holds, and that the reset walk clears it.

// File: rtl/tap_pkg.sv
// Shared types for the boundary-scan controller: controller states and opcodes.
// Assumes a 4-bit instruction register.
package tap_pkg;
    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
    localparam logic [IR_W-1:0] OP_DEVRST  = 4'hC;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller. It advances on rising tck according to tms.
// Assumes rst_n is synchronous to tck.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;

    // Next-state selection for every controller state.
    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end

    assert_tlr_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR && tms) |=> (state == ST_TLR));
endmodule

// File: rtl/tap_ir.sv
// Instruction register: a shift stage plus a latched copy that drives decode.
// Assumes the state comes from tap_fsm on the same tck.
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic            so,
    output logic [IR_W-1:0] ir
);
    logic [IR_W-1:0] sr;

    // Shift stage: loads the capture pattern in Capture-IR and shifts in Shift-IR.
    always_ff @(posedge tck) begin
        if (!rst_n)                 sr <= '0;
        else if (state == ST_CAP_IR) sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  sr <= {tdi, sr[IR_W-1:1]};
    end

    // Latched instruction: loads in Update-IR and returns to BYPASS in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_TLR) ir <= OP_BYPASS;
        else if (state == ST_UPD_IR)   ir <= sr;
    end

    assign so = sr[0];
endmodule

// File: rtl/bscan_chain.sv
// Boundary chain with four cells per pin (pull-up disable, output enable,
// output value, input level) and update latches for the three output cells.
// Assumes the enables are asserted only while EXTEST is the selected instruction.
module bscan_chain #(
    parameter int NPINS = 4
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             sh_en,
    input  logic             upd_en,
    input  logic             tdi,
    input  logic [NPINS-1:0] core_pud,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] core_out,
    input  logic [NPINS-1:0] pin_in,
    output logic             so,
    output logic [NPINS-1:0] lat_pud,
    output logic [NPINS-1:0] lat_oe,
    output logic [NPINS-1:0] lat_out
);
    localparam int CELLS = 4 * NPINS;

    logic [CELLS-1:0] chain;
    logic [CELLS-1:0] cap_vec;

    // Per-pin wiring of the capture sources into the chain layout.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign cap_vec[4*i+0] = core_pud[i];
        assign cap_vec[4*i+1] = core_oe[i];
        assign cap_vec[4*i+2] = core_out[i];
        assign cap_vec[4*i+3] = pin_in[i];
    end

    // Shift chain: capture, then shift toward cell 0.
    always_ff @(posedge tck) begin
        if (!rst_n)      chain <= '0;
        else if (cap_en) chain <= cap_vec;
        else if (sh_en)  chain <= {tdi, chain[CELLS-1:1]};
    end

    // Update latches: copy the output cells in Update-DR.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            lat_pud <= '0;
            lat_oe  <= '0;
            lat_out <= '0;
        end else if (upd_en) begin
            for (int i = 0; i < NPINS; i++) begin
                lat_pud[i] <= chain[4*i+0];
                lat_oe[i]  <= chain[4*i+1];
                lat_out[i] <= chain[4*i+2];
            end
        end
    end

    assign so = chain[0];
endmodule

// File: rtl/tap_bscan_ctrl.sv
// Top of the boundary-scan controller. It holds the bypass bit and the reset
// bit, selects the serial output, drives tdo on falling tck and multiplexes
// the pads between core and boundary latches.
// Assumes rst_n is synchronous to tck and NPINS >= 1.
module tap_bscan_ctrl
    import tap_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [NPINS-1:0] core_pud,
    input  logic [NPINS-1:0] core_oe,
    input  logic [NPINS-1:0] core_out,
    output logic [NPINS-1:0] core_in,
    output logic [NPINS-1:0] pin_pud,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out,
    input  logic [NPINS-1:0] pin_in,
    output logic             core_rst_req
);
    tap_state_t      state;
    logic [IR_W-1:0] ir;
    logic            ir_so, chain_so;
    logic [NPINS-1:0] lat_pud, lat_oe, lat_out;
    logic            bypass_q, rstbit_q;
    logic            sel_ext, sel_rst, sel_byp, dr_bit, out_bit;

    assign sel_ext = (ir == OP_EXTEST);
    assign sel_rst = (ir == OP_DEVRST);
    assign sel_byp = !sel_ext && !sel_rst;

    tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

    tap_ir u_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi), .so(ir_so), .ir(ir));

    bscan_chain #(.NPINS(NPINS)) u_chain (
        .tck(tck), .rst_n(rst_n),
        .cap_en(sel_ext && state == ST_CAP_DR),
        .sh_en(sel_ext && state == ST_SH_DR),
        .upd_en(sel_ext && state == ST_UPD_DR),
        .tdi(tdi),
        .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .pin_in(pin_in),
        .so(chain_so), .lat_pud(lat_pud), .lat_oe(lat_oe), .lat_out(lat_out)
    );

    // Bypass bit: captures 0 and shifts tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                               bypass_q <= 1'b0;
        else if (sel_byp && state == ST_CAP_DR)   bypass_q <= 1'b0;
        else if (sel_byp && state == ST_SH_DR)    bypass_q <= tdi;
    end

    // Reset bit: unlatched, takes tdi on each shift and clears in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_TLR)          rstbit_q <= 1'b0;
        else if (sel_rst && state == ST_SH_DR)  rstbit_q <= tdi;
    end

    assign core_rst_req = rstbit_q;

    // Serial output source for the current shift path.
    always_comb begin
        if (sel_ext)      dr_bit = chain_so;
        else if (sel_rst) dr_bit = rstbit_q;
        else              dr_bit = bypass_q;
        out_bit = (state == ST_SH_IR) ? ir_so : dr_bit;
    end

    // Falling-edge output stage for tdo and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= out_bit;
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    // Pad multiplexer: boundary latches under EXTEST, core otherwise, enables off in reset.
    always_comb begin
        if (sel_ext) begin
            pin_pud = lat_pud;
            pin_oe  = lat_oe;
            pin_out = lat_out;
        end else begin
            pin_pud = core_pud;
            pin_oe  = core_rst_req ? '0 : core_oe;
            pin_out = core_out;
        end
    end

    assign core_in = pin_in;

    assert_tlr_clears_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> (core_rst_req == 1'b0));

    assert_rst_unlatched_R7: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_rst && state == ST_SH_DR) |=> (core_rst_req == $past(tdi)));

    assert_latch_hold_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_ext && state != ST_UPD_DR && state != ST_UPD_IR && state != ST_TLR)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pud)));

    assert_tdo_en_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (state == ST_SH_IR || state == ST_SH_DR));
endmodule

// File: tb/tap_bscan_ctrl_bench.sv
module tap_bscan_ctrl_bench;
    localparam int NP = 4;

    logic tck = 1'b0;
    logic rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, core_rst_req;
    logic [NP-1:0] core_pud = 4'hA, core_oe = 4'hC, core_out = 4'h6, pin_in = 4'h9;
    logic [NP-1:0] core_in, pin_pud, pin_oe, pin_out;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 tck = ~tck;

    tap_bscan_ctrl #(.NPINS(NP)) u_tap_bscan_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out), .core_in(core_in),
        .pin_pud(pin_pud), .pin_oe(pin_oe), .pin_out(pin_out), .pin_in(pin_in),
        .core_rst_req(core_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One test clock: set inputs, pass a rising and a falling edge.
    task automatic clk(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic shift_ir(input logic [3:0] din, output logic [3:0] dout);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 4; i++) begin
            dout[i] = tdo;
            clk(i == 3, din[i]);
        end
        clk(1, 0); clk(0, 0);
    endtask

    // From Run-Test/Idle to Exit1-DR after n shifts.
    task automatic dr_shift(input int n, input logic [15:0] din, output logic [15:0] dout);
        dout = '0;
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            clk(i == n - 1, din[i]);
        end
    endtask

    task automatic dr_finish();
        clk(1, 0); clk(0, 0);
    endtask

    task automatic t_reset();
        chk("R1 tdo_en after reset", tdo_en, 0);
        chk("R1 rst_req after reset", core_rst_req, 0);
        chk("R1 pin_oe follows core", pin_oe, core_oe);
        chk("R1 pin_out follows core", pin_out, core_out);
        chk("R1 pin_pud follows core", pin_pud, core_pud);
    endtask

    task automatic t_ir_capture();
        logic [3:0] o;
        shift_ir(4'hF, o);
        chk("R2 capture-IR pattern", o, 4'b0001);
    endtask

    task automatic t_bypass(input logic [3:0] op, input string tag);
        logic [3:0] o; logic [15:0] d;
        shift_ir(op, o);
        dr_shift(8, 16'h00A5, d); dr_finish();
        chk(tag, d[7:0], {8'hA5 << 1});
    endtask

    task automatic t_tdo_edge();
        clk(1, 0); clk(0, 0);
        tms = 0;
        @(posedge tck); #1;
        chk("R9 tdo_en not yet at rise", tdo_en, 0);
        @(negedge tck); #1;
        chk("R9 tdo_en at fall in shift", tdo_en, 1);
        clk(1, 0);
        chk("R9 tdo_en off in exit1", tdo_en, 0);
        dr_finish();
    endtask

    task automatic t_extest();
        logic [3:0] o; logic [15:0] d, cap, pat;
        logic [3:0] ep, eo, ev;
        pat = 16'hB35E;
        for (int i = 0; i < NP; i++) begin
            cap[4*i+0] = core_pud[i]; cap[4*i+1] = core_oe[i];
            cap[4*i+2] = core_out[i]; cap[4*i+3] = pin_in[i];
            ep[i] = pat[4*i]; eo[i] = pat[4*i+1]; ev[i] = pat[4*i+2];
        end
        shift_ir(4'h0, o);
        chk("R6 EXTEST oe at once", pin_oe, 4'h0);
        chk("R6 EXTEST out at once", pin_out, 4'h0);
        dr_shift(16, pat, d);
        chk("R5 R4 capture readout", d, cap);
        chk("R6 latch holds before update", pin_oe, 4'h0);
        dr_finish();
        chk("R4 pud after update", pin_pud, ep);
        chk("R4 oe after update", pin_oe, eo);
        chk("R4 out after update", pin_out, ev);
    endtask

    task automatic t_devreset();
        logic [3:0] o; logic [15:0] d;
        shift_ir(4'hC, o);
        dr_shift(1, 16'h1, d);
        chk("R7 rst_req before update", core_rst_req, 1);
        chk("R8 pins tri-stated", pin_oe, 4'h0);
        dr_finish();
        chk("R7 rst_req holds", core_rst_req, 1);
        for (int i = 0; i < 5; i++) clk(1, 0);
        chk("R10 rst_req cleared by TLR", core_rst_req, 0);
        chk("R10 pin_oe back to core", pin_oe, core_oe);
        clk(0, 0);
        dr_shift(8, 16'h003C, d); dr_finish();
        chk("R1 IR is BYPASS after TLR", d[7:0], 8'h78);
    endtask

    initial begin
        repeat (3) clk(1, 0);
        rst_n = 1'b1;
        clk(0, 0);
        t_reset();
        t_ir_capture();
        t_bypass(4'hF, "R3 bypass opcode F");
        t_bypass(4'h5, "R3 unused opcode 5");
        t_tdo_edge();
        t_extest();
        t_devreset();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule